// File: doc/BRIEF.md
# Two-Class Round-Robin Bus Arbiter

This block decides which of four masters may drive a shared parallel bus. Three masters sit outside the chip and use active-low request and grant lines. The fourth is the on-chip bridge, which uses active-high request and grant pins. A 16-bit configuration word gives each master a high or low priority class and picks where an idle bus is parked. It also holds a disable flag, which is captured from a strap pin while reset is asserted.

While enabled, the block registers all requests once. A pending high-class request always beats every low-class request. Among requests of the same class, the winner is the next master after the last one granted in that class. A grant is only handed out while the bus is idle, which means the frame and ready lines are both high. The current holder keeps its grant for as long as it keeps requesting. When the holder drops its request and the grant has to move, the old grant is withdrawn and at least one cycle with no grant passes before the next grant appears. When nothing is requested, the grant is parked either on the last master to use the bus or on the bridge.

When the strap disables the block, it issues no grants of its own. The bridge's request is forwarded to an outside arbiter, and the bridge's grant is taken from that arbiter.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted, every external grant is high, `br_gnt` is low, `up_req_n` is high, and `cfg_rdata` equals the strap value in bit 15 with every other bit zero.
- R2: A write with `cfg_we` sets bit 14 (park on bridge), bits 6, 5 and 4 (high class for external masters 0, 1 and 2) and bit 0 (high class for the bridge). Bits 13..7 and 3..1 always read zero. Writes never change bit 15.
- R3: A request asserted before rising edge k can first produce a grant after edge k+1. A grant appears only after an edge at which `frame_n` and `irdy_n` are both high.
- R4: At most one of the four grants is active in any cycle.
- R5: Any pending high-class request is granted ahead of all pending low-class requests.
- R6: Within one class, the winner is the first requester after that class's last granted master, in the cyclic order ext0, ext1, ext2, bridge.
- R7: A holder that keeps requesting keeps its grant, even when other requests are pending.
- R8: When the holder stops requesting and another request is pending, or the park target differs from the holder, the grant is removed. No grant is active in the cycle after the removal.
- R9: With no requests pending and the bus idle, the grant parks on the last granted master when bit 14 is 0, or on the bridge when bit 14 is 1. The last granted master is the bridge until the first grant after reset. A parked master keeps its grant while nothing is requested.
- R10: When bit 15 is 1, all external grants stay high, `up_req_n` is the inverse of `br_req`, and `br_gnt` is the inverse of `up_gnt_n`. When bit 15 is 0, `up_req_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_arb_dis | input | 1 | Strap value captured into bit 15 during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration word |
| req_n | input | 3 | External master requests, active low |
| gnt_n | output | 3 | External master grants, active low |
| br_req | input | 1 | Bridge request, active high |
| br_gnt | output | 1 | Bridge grant, active high |
| frame_n | input | 1 | Bus frame indication, active low |
| irdy_n | input | 1 | Bus ready indication, active low |
| up_req_n | output | 1 | Bridge request toward the outside arbiter when disabled |
| up_gnt_n | input | 1 | Grant from the outside arbiter when disabled |

## Verification
Directed patterns separate the selection rules from each other. A simultaneous high/low pair shows class priority overriding index order. A rotation across three low-class requesters, ending with the bridge chosen over a lower-indexed master, shows round-robin order as distinct from fixed priority. Holding the frame line low while requests are pending shows that a grant waits for an idle bus. Long randomized runs, with request churn, busy bus cycles and occasional rewrites of priority and parking, are checked every cycle against a bench model; these expose timing slips in hand-off, the gap cycle and parking. A reset with the strap set then covers pass-through mode.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CFG_W      = 16;
  localparam int DIS_BIT    = 15;
  localparam int PARK_BIT   = 14;
  localparam int EPRIO_TOP  = 6;
  localparam int BPRIO_BIT  = 0;

  // bits that hold state for a given number of external masters
  function automatic logic [CFG_W-1:0] cfg_live_mask(int n_ext);
    logic [CFG_W-1:0] m;
    m = '0;
    m[DIS_BIT]   = 1'b1;
    m[PARK_BIT]  = 1'b1;
    m[BPRIO_BIT] = 1'b1;
    for (int i = 0; i < n_ext; i++) m[EPRIO_TOP-i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import arb_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int NUM   = N_EXT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_dis,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             dis,
  output logic             park_br,
  output logic [NUM-1:0]   prio
);
  localparam logic [CFG_W-1:0] LIVE = cfg_live_mask(N_EXT);

  logic             dis_q;
  logic             park_q;
  logic             bprio_q;
  logic [N_EXT-1:0] eprio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= strap_dis;
      park_q  <= 1'b0;
      bprio_q <= 1'b0;
      eprio_q <= '0;
    end else if (we) begin
      park_q  <= wdata[PARK_BIT];
      bprio_q <= wdata[BPRIO_BIT];
      for (int i = 0; i < N_EXT; i++) eprio_q[i] <= wdata[EPRIO_TOP-i];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[DIS_BIT]   = dis_q;
    rdata[PARK_BIT]  = park_q;
    rdata[BPRIO_BIT] = bprio_q;
    for (int i = 0; i < N_EXT; i++) rdata[EPRIO_TOP-i] = eprio_q[i];
  end

  assign dis     = dis_q;
  assign park_br = park_q;
  assign prio    = {bprio_q, eprio_q};

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~LIVE);
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM = 4,
  parameter int IW  = $clog2(NUM)
) (
  input  logic [NUM-1:0] req,
  input  logic [IW-1:0]  last,
  output logic           valid,
  output logic [IW-1:0]  idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int off = 1; off <= NUM; off++) begin
      int k;
      k = (int'(last) + off) % NUM;
      if (!valid && req[k]) begin
        valid = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
  parameter int NUM = 4,
  parameter int IW  = $clog2(NUM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           bus_idle,
  input  logic [NUM-1:0] req,
  input  logic [NUM-1:0] prio,
  input  logic           park_br,
  output logic [NUM-1:0] gnt
);
  localparam logic [IW-1:0] BR = IW'(NUM - 1);

  logic [NUM-1:0] gnt_q, gnt_d;
  logic [IW-1:0]  last_q, last_d;
  logic [IW-1:0]  ptr_q [2];
  logic [IW-1:0]  ptr_d [2];
  logic [1:0]     cls_vld;
  logic [IW-1:0]  cls_idx [2];

  // class 0 = low, class 1 = high
  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NUM-1:0] mask;
    assign mask = req & ((c == 1) ? prio : ~prio);
    arb_rr_pick #(.NUM(NUM), .IW(IW)) u_pick (
      .req  (mask),
      .last (ptr_q[c]),
      .valid(cls_vld[c]),
      .idx  (cls_idx[c])
    );
  end

  logic           any_req;
  logic           win_cls;
  logic [IW-1:0]  win;
  logic [IW-1:0]  park_tgt;
  logic [NUM-1:0] park_vec;
  logic           holder_req;

  always_comb begin
    any_req    = |req;
    win_cls    = cls_vld[1];
    win        = win_cls ? cls_idx[1] : cls_idx[0];
    park_tgt   = park_br ? BR : last_q;
    park_vec   = NUM'(1) << park_tgt;
    holder_req = |(gnt_q & req);

    gnt_d  = gnt_q;
    last_d = last_q;
    ptr_d  = ptr_q;
    if (!enable) begin
      gnt_d = '0;
    end else if (|gnt_q) begin
      if (!holder_req && !(!any_req && gnt_q == park_vec)) gnt_d = '0;
    end else if (bus_idle) begin
      if (any_req) begin
        gnt_d          = NUM'(1) << win;
        last_d         = win;
        ptr_d[win_cls] = win;
      end else begin
        gnt_d = park_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q    <= '0;
      last_q   <= BR;
      ptr_q[0] <= BR;
      ptr_q[1] <= BR;
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
      ptr_q  <= ptr_d;
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_arb_dis,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [N_EXT-1:0] req_n,
  output logic [N_EXT-1:0] gnt_n,
  input  logic             br_req,
  output logic             br_gnt,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic             up_req_n,
  input  logic             up_gnt_n
);
  localparam int NUM = N_EXT + 1;

  logic           cfg_dis;
  logic           cfg_park_br;
  logic [NUM-1:0] cfg_prio;
  logic [NUM-1:0] req_q;
  logic [NUM-1:0] gnt_v;
  logic           bus_idle;

  arb_cfg_reg #(.N_EXT(N_EXT), .NUM(NUM)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_dis(strap_arb_dis),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .dis      (cfg_dis),
    .park_br  (cfg_park_br),
    .prio     (cfg_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= {br_req, ~req_n};
  end

  assign bus_idle = frame_n & irdy_n;

  arb_grant_ctrl #(.NUM(NUM)) u_gnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (~cfg_dis),
    .bus_idle(bus_idle),
    .req     (req_q),
    .prio    (cfg_prio),
    .park_br (cfg_park_br),
    .gnt     (gnt_v)
  );

  assign gnt_n    = ~gnt_v[N_EXT-1:0];
  assign br_gnt   = cfg_dis ? ~up_gnt_n : gnt_v[N_EXT];
  assign up_req_n = ~(cfg_dis & br_req);
endmodule

// File: rtl/arb_bus_chk.sv
module arb_bus_chk
  import arb_pkg::*;
#(
  parameter int N_EXT = 3,
  parameter int NUM   = N_EXT + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [N_EXT-1:0] gnt_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [NUM-1:0]   req_q,
  input logic [NUM-1:0]   gnt_v,
  input logic             dis
);
  localparam logic [CFG_W-1:0] RSVD = ~cfg_live_mask(N_EXT);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & RSVD) == '0); // R2

  AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_v)); // R4

  AST_IDLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt_v) |-> $past(frame_n && irdy_n)); // R3

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis && |(gnt_v & req_q)) |=> gnt_v == $past(gnt_v)); // R7

  AST_GAP_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_v && $past(|gnt_v)) |-> gnt_v == $past(gnt_v)); // R8

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> &gnt_n); // R10
endmodule

bind bus_arbiter arb_bus_chk #(.N_EXT(N_EXT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_rdata(cfg_rdata),
  .gnt_n    (gnt_n),
  .frame_n  (frame_n),
  .irdy_n   (irdy_n),
  .req_q    (req_q),
  .gnt_v    (gnt_v),
  .dis      (cfg_dis)
);

// File: tb/bus_arbiter_tb.sv
`timescale 1ns/1ps
module bus_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [2:0]  req_n = 3'b111;
  logic [2:0]  gnt_n;
  logic        br_req = 1'b0;
  logic        br_gnt;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        up_req_n;
  logic        up_gnt_n = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  bit mdl_on = 1'b1;

  always #5 clk = ~clk;

  bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .strap_arb_dis(strap),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_n(req_n), .gnt_n(gnt_n), .br_req(br_req), .br_gnt(br_gnt),
    .frame_n(frame_n), .irdy_n(irdy_n), .up_req_n(up_req_n), .up_gnt_n(up_gnt_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] owner();
    return {br_gnt, ~gnt_n};
  endfunction

  // next requester after last in cyclic order 0,1,2,bridge
  function automatic int pick(logic [3:0] r, int last);
    for (int off = 1; off <= 4; off++) begin
      int k;
      k = (last + off) % 4;
      if (r[k]) return k;
    end
    return 0;
  endfunction

  // reference model built from the requirements
  logic [3:0] m_req, m_gnt, m_prio;
  int         m_last, m_plo, m_phi;
  logic       m_park, m_dis;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req <= '0; m_gnt <= '0; m_prio <= '0; m_park <= 1'b0;
      m_last <= 3; m_plo <= 3; m_phi <= 3; m_dis <= strap;
    end else begin
      logic [3:0] hi, lo, pv;
      int ptgt, w;
      m_req <= {br_req, ~req_n};
      if (cfg_we) begin
        m_park <= cfg_wdata[14];
        m_prio <= {cfg_wdata[0], cfg_wdata[4], cfg_wdata[5], cfg_wdata[6]};
      end
      hi   = m_req & m_prio;
      lo   = m_req & ~m_prio;
      ptgt = m_park ? 3 : m_last;
      pv   = 4'(1) << ptgt;
      if (m_dis) m_gnt <= '0;
      else if (m_gnt != 0) begin
        if ((m_gnt & m_req) == 0 && !(m_req == 0 && m_gnt == pv)) m_gnt <= '0;
      end else if (frame_n && irdy_n) begin
        if (m_req != 0) begin
          if (hi != 0) begin w = pick(hi, m_phi); m_phi <= w; end
          else begin w = pick(lo, m_plo); m_plo <= w; end
          m_last <= w;
          m_gnt  <= 4'(1) << w;
        end else m_gnt <= pv;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mdl_on) begin
      #1;
      chk("R8 model grant vector", {28'd0, owner()},
          {28'd0, (m_dis ? {~up_gnt_n, 3'b000} : m_gnt)});
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_owner(string tag, logic [3:0] e);
    #1;
    chk(tag, {28'd0, owner()}, {28'd0, e});
  endtask

  initial begin : watchdog
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0A21));
    // R1 reset state
    run(2);
    #1;
    chk("R1 gnt_n", {29'd0, gnt_n}, 32'h7);
    chk("R1 br_gnt", {31'd0, br_gnt}, 32'h0);
    chk("R1 up_req_n", {31'd0, up_req_n}, 32'h1);
    chk("R1 cfg_rdata", {16'd0, cfg_rdata}, 32'h0000);
    rst_n = 1'b1;
    // R9 park on bridge after reset with no requests
    run(2);
    expect_owner("R9 initial park on bridge", 4'b1000);
    // R2 writable fields and reserved bits
    wr_cfg(16'hFFFF);
    #1 chk("R2 write all ones", {16'd0, cfg_rdata}, 32'h4071);
    wr_cfg(16'h0000);
    #1 chk("R2 write zero", {16'd0, cfg_rdata}, 32'h0000);
    // R5 ext2 high class beats ext0 low class
    wr_cfg(16'h0010);
    req_n = 3'b010;
    run(6);
    expect_owner("R5 high class wins", 4'b0100);
    // R8 drop holder, pending one takes over
    req_n = 3'b110;
    run(6);
    expect_owner("R8 hand-off to ext0", 4'b0001);
    // R7 no preemption
    wr_cfg(16'h0000);
    req_n = 3'b000;
    run(6);
    expect_owner("R7 holder keeps grant", 4'b0001);
    // R6 rotation inside the low class
    req_n = 3'b001;
    run(6);
    expect_owner("R6 after ext0 comes ext1", 4'b0010);
    req_n = 3'b011; br_req = 1'b1;
    run(6);
    expect_owner("R6 after ext1 comes ext2", 4'b0100);
    req_n = 3'b101;
    run(6);
    expect_owner("R6 after ext2 comes bridge", 4'b1000);
    req_n = 3'b111; br_req = 1'b0;
    run(6);
    expect_owner("R9 bridge stays parked", 4'b1000);
    // R9 park on bridge mode
    wr_cfg(16'h4000);
    req_n = 3'b101;
    run(6);
    expect_owner("R9 ext1 granted", 4'b0010);
    req_n = 3'b111;
    run(6);
    expect_owner("R9 parked on bridge", 4'b1000);
    // R9 park on last user
    wr_cfg(16'h0000);
    req_n = 3'b101;
    run(6);
    req_n = 3'b111;
    run(6);
    expect_owner("R9 parked on last user", 4'b0010);
    // R3 busy bus blocks new grants
    frame_n = 1'b0;
    req_n = 3'b110;
    run(8);
    expect_owner("R3 no grant while busy", 4'b0000);
    frame_n = 1'b1;
    run(3);
    expect_owner("R3 grant once idle", 4'b0001);
    // random phase, R4 R8 checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if ($urandom_range(3) == 0) req_n = 3'($urandom);
      if ($urandom_range(5) == 0) br_req = 1'($urandom);
      frame_n = ($urandom_range(3) != 0);
      irdy_n  = ($urandom_range(4) != 0);
      if ($urandom_range(60) == 0) begin
        cfg_we = 1'b1; cfg_wdata = 16'($urandom);
      end
    end
    @(negedge clk);
    cfg_we = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
    // R10 disabled by strap
    rst_n = 1'b0; strap = 1'b1;
    run(2);
    #1 chk("R1 strap in bit 15", {16'd0, cfg_rdata}, 32'h8000);
    rst_n = 1'b1;
    wr_cfg(16'h7FFF);
    #1 chk("R2 bit 15 not writable", {16'd0, cfg_rdata}, 32'hC071);
    req_n = 3'b000; br_req = 1'b1; up_gnt_n = 1'b1;
    run(5);
    #1;
    chk("R10 no external grants", {29'd0, gnt_n}, 32'h7);
    chk("R10 request forwarded", {31'd0, up_req_n}, 32'h0);
    chk("R10 no grant yet", {31'd0, br_gnt}, 32'h0);
    @(negedge clk);
    up_gnt_n = 1'b0;
    #1 chk("R10 grant from outside", {31'd0, br_gnt}, 32'h1);
    @(negedge clk);
    br_req = 1'b0;
    #1 chk("R10 request released", {31'd0, up_req_n}, 32'h1);
    run(4);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule